// File: doc/BRIEF.md
# Serial Control Register Slave

This block is a two-wire serial slave that lets a bus master load a bank of control registers and read back a single byte of status. Both bus lines are sampled on the system clock, passed through a synchronizer and a glitch filter, and then decoded into start, repeated-start and stop conditions and data bits. After a start, the master sends the device address; a write message carries a subaddress byte followed by any number of data bytes, and each byte lands in the register the subaddress points to, with the subaddress stepping forward after every byte.

The addressed registers can only be written. The status byte has no subaddress: the master issues a start and the read form of the device address, clocks in one byte, answers with a not-acknowledge and ends with a stop. The slave drives the data line only through an active-low open-drain enable and only while the clock line is low. A power-good input gates everything: while it is low the slave stays silent, never acknowledges and holds every register at its default value.

Top module: `ctrl_bus_slave`

## Requirements
- R1: The slave acknowledges (pulls the data line low during the ninth clock) an address byte whose upper seven bits equal the 7-bit device address 0x46, that is the byte 0x8C for a write and 0x8D for a read.
- R2: After an address byte with any other upper seven bits the slave acknowledges nothing and changes no register until the next start condition.
- R3: In a write message the byte after the address is the subaddress; register index = subaddress modulo NUM_REGS (a power of two). Each following data byte is stored in the indexed register, and the index then advances by one, wrapping from NUM_REGS-1 to 0. Register i appears on `regFlat` bits 8i+7 down to 8i. Each subaddress and data byte is acknowledged.
- R4: A repeated start inside a message is accepted; the master may send the address again and a new subaddress without a stop.
- R5: After a read address the slave shifts out `statusIn` most significant bit first on the next eight clocks and releases the line for the master's acknowledge bit; register contents are never returned.
- R6: A pulse on either bus line shorter than FILT_N system clocks is ignored and neither corrupts data nor creates a start or stop.
- R7: While `pwrGood` is low the slave never drives the data line, acknowledges nothing, and every register holds its default value (0x00 by default); after `pwrGood` returns, normal writes resume.
- R8: The data-line drive enable changes only while the bus clock line is low.
- R9: After reset all registers hold their default value and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrGood | input | 1 | High when supply is valid; low silences the slave and clears the registers |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaDrvLow | output | 1 | Open-drain enable: 1 pulls the data line low, 0 releases it |
| statusIn | input | 8 | Status byte returned on a read |
| regFlat | output | NUM_REGS*8 | Contents of the write-only register bank |

## Verification
The bench drives bursts that start near the top of the register bank so the subaddress has to wrap, where a design that saturated or dropped the carry would overwrite the last register or leave register 0 untouched. It sends wrong addresses followed by full bytes, which a slave that kept decoding after a mismatch would acknowledge or store. Two-cycle pulses on both lines in the middle of a clock-high phase target the filter: a leaky filter turns them into an extra bit or a false start or stop and the burst lands wrongly. Power is dropped with written registers and a full message is sent while it is low, which catches a slave that keeps old values or still acknowledges; the drive enable is watched throughout for any change while the clock line is high.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } busState_t;

  // Strobes from the protocol control to the datapath, one cycle wide.
  typedef struct packed {
    logic shiftIn;   // take one received bit
    logic capSub;    // received byte becomes the subaddress
    logic writeReg;  // store received byte, advance subaddress
    logic loadTx;    // load status byte for transmission
    logic shiftTx;   // move to the next status bit
  } dpStrobe_t;

endpackage

// File: rtl/cbs_line_filter.sv
module cbs_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_N      = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic lineOut
);

  localparam int CNT_W = $clog2(FILT_N + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_N - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       runCnt;
  logic                   sample;

  assign sample = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
    end
  end

  // The filtered level follows only after FILT_N equal differing samples.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt  <= '0;
      lineOut <= 1'b1;
    end else if (sample == lineOut) begin
      runCnt <= '0;
    end else if (runCnt == CNT_LAST) begin
      runCnt  <= '0;
      lineOut <= sample;
    end else begin
      runCnt <= runCnt + CNT_ONE;
    end
  end

endmodule

// File: rtl/cbs_control.sv
module cbs_control
  import cbs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h46
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pwrGood,
  input  logic      sclF,
  input  logic      sdaF,
  input  logic [7:0] rxByte,
  input  logic      txMsb,
  output dpStrobe_t strobe,
  output logic      sdaDrvLow
);

  localparam logic [3:0] BITS_PER_BYTE = 4'd8;
  localparam logic [3:0] CNT_ONE       = 4'd1;

  busState_t  state, stateNx;
  logic [3:0] bitCnt, bitCntNx;
  logic       ackDrv, ackDrvNx;
  logic       sclPrev, sdaPrev;
  logic       sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  assign sclRise  = sclF & ~sclPrev;
  assign sclFall  = ~sclF & sclPrev;
  assign startDet = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopDet  = sclF & sclPrev & ~sdaPrev & sdaF;

  always_comb begin
    stateNx  = state;
    bitCntNx = bitCnt;
    ackDrvNx = ackDrv;
    strobe   = '0;
    if (!pwrGood) begin
      stateNx  = ST_IDLE;
      bitCntNx = '0;
      ackDrvNx = 1'b0;
    end else if (startDet) begin
      stateNx  = ST_ADDR;
      bitCntNx = '0;
      ackDrvNx = 1'b0;
    end else if (stopDet) begin
      stateNx  = ST_IDLE;
      bitCntNx = '0;
      ackDrvNx = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (sclRise && bitCnt < BITS_PER_BYTE) begin
            strobe.shiftIn = 1'b1;
            bitCntNx       = bitCnt + CNT_ONE;
          end else if (sclFall && bitCnt == BITS_PER_BYTE) begin
            bitCntNx = '0;
            if (state == ST_ADDR) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                stateNx  = ST_ADDR_ACK;
                ackDrvNx = 1'b1;
              end else begin
                stateNx = ST_IDLE;
              end
            end else if (state == ST_SUB) begin
              strobe.capSub = 1'b1;
              stateNx       = ST_SUB_ACK;
              ackDrvNx      = 1'b1;
            end else begin
              strobe.writeReg = 1'b1;
              stateNx         = ST_WDATA_ACK;
              ackDrvNx        = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ackDrvNx = 1'b0;
            bitCntNx = '0;
            if (rxByte[0]) begin
              stateNx       = ST_RDATA;
              strobe.loadTx = 1'b1;
            end else begin
              stateNx = ST_SUB;
            end
          end
        end
        ST_SUB_ACK, ST_WDATA_ACK: begin
          if (sclFall) begin
            ackDrvNx = 1'b0;
            bitCntNx = '0;
            stateNx  = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclRise && bitCnt < BITS_PER_BYTE) begin
            bitCntNx = bitCnt + CNT_ONE;
          end else if (sclFall) begin
            if (bitCnt == BITS_PER_BYTE) begin
              stateNx  = ST_RDATA_ACK;
              bitCntNx = '0;
            end else if (bitCnt != 4'd0) begin
              strobe.shiftTx = 1'b1;
            end
          end
        end
        ST_RDATA_ACK: begin
          if (sclFall) stateNx = ST_IDLE;
        end
        default: begin
          stateNx  = ST_IDLE;
          bitCntNx = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      ackDrv <= 1'b0;
    end else begin
      state  <= stateNx;
      bitCnt <= bitCntNx;
      ackDrv <= ackDrvNx;
    end
  end

  assign sdaDrvLow = pwrGood & (ackDrv | (state == ST_RDATA && !txMsb));

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN || !pwrGood)
    !$stable(sdaDrvLow) |-> !sclF) else $error("drive changed with clock high"); // R8

  AST_ACK_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rstN || !pwrGood)
    ($rose(ackDrv) && $past(state) == ST_ADDR) |-> $past(rxByte[7:1]) == DEV_ADDR)
    else $error("acknowledged a foreign address"); // R2

  AST_PWR_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrGood) |=> (state == ST_IDLE && !ackDrv)) else $error("active without power"); // R7

endmodule

// File: rtl/cbs_datapath.sv
module cbs_datapath
  import cbs_pkg::*;
#(
  parameter int         NUM_REGS  = 16,
  parameter int         SUB_W     = 4,
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pwrGood,
  input  logic                  sdaF,
  input  dpStrobe_t             strobe,
  input  logic [7:0]            statusIn,
  output logic [7:0]            rxByte,
  output logic                  txMsb,
  output logic [NUM_REGS*8-1:0] regFlat
);

  localparam logic [SUB_W-1:0] SUB_ONE = SUB_W'(1);

  logic [7:0]       shiftReg;
  logic [7:0]       txShift;
  logic [SUB_W-1:0] subPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.shiftIn) begin
      shiftReg <= {shiftReg[6:0], sdaF};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subPtr <= '0;
    end else if (!pwrGood) begin
      subPtr <= '0;
    end else if (strobe.capSub) begin
      subPtr <= shiftReg[SUB_W-1:0];
    end else if (strobe.writeReg) begin
      subPtr <= subPtr + SUB_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobe.loadTx) begin
      txShift <= statusIn;
    end else if (strobe.shiftTx) begin
      txShift <= {txShift[6:0], 1'b0};
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [7:0] regQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ <= RESET_VAL;
      end else if (!pwrGood) begin
        regQ <= RESET_VAL;
      end else if (strobe.writeReg && subPtr == SUB_W'(i)) begin
        regQ <= shiftReg;
      end
    end
    assign regFlat[i*8 +: 8] = regQ;
  end

  assign rxByte = shiftReg;
  assign txMsb  = txShift[7];

  AST_SUB_INCREMENT: assert property (@(posedge clk) disable iff (!rstN || !pwrGood)
    strobe.writeReg |=> subPtr == SUB_W'($past(subPtr) + SUB_ONE))
    else $error("subaddress did not advance"); // R3

  AST_TX_LOAD_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTx |=> txShift == $past(statusIn)) else $error("status not loaded"); // R5

  AST_REGS_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> regFlat == {NUM_REGS{RESET_VAL}}) else $error("registers kept without power"); // R7

endmodule

// File: rtl/ctrl_bus_slave.sv
module ctrl_bus_slave
  import cbs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h46,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_N      = 3,
  parameter logic [7:0] RESET_VAL   = 8'h00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pwrGood,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaDrvLow,
  input  logic [7:0]            statusIn,
  output logic [NUM_REGS*8-1:0] regFlat
);

  localparam int SUB_W = $clog2(NUM_REGS);
  localparam int LINES = 2;

  logic [LINES-1:0] rawLines;
  logic [LINES-1:0] filtLines;
  dpStrobe_t        strobe;
  logic [7:0]       rxByte;
  logic             txMsb;

  assign rawLines = {sdaIn, sclIn};

  for (genvar k = 0; k < LINES; k++) begin : g_line
    cbs_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_N     (FILT_N)
    ) u_filter (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (rawLines[k]),
      .lineOut(filtLines[k])
    );
  end

  cbs_control #(
    .DEV_ADDR(DEV_ADDR)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .pwrGood  (pwrGood),
    .sclF     (filtLines[0]),
    .sdaF     (filtLines[1]),
    .rxByte   (rxByte),
    .txMsb    (txMsb),
    .strobe   (strobe),
    .sdaDrvLow(sdaDrvLow)
  );

  cbs_datapath #(
    .NUM_REGS (NUM_REGS),
    .SUB_W    (SUB_W),
    .RESET_VAL(RESET_VAL)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .pwrGood (pwrGood),
    .sdaF    (filtLines[1]),
    .strobe  (strobe),
    .statusIn(statusIn),
    .rxByte  (rxByte),
    .txMsb   (txMsb),
    .regFlat (regFlat)
  );

endmodule

// File: tb/ctrl_bus_slave_bench.sv
module ctrl_bus_slave_bench;

  localparam int Q    = 12;
  localparam int NREG = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rstN, pwrGood, mScl, mSda, sdaDrvLow;
  logic [7:0]      statusIn;
  logic [NREG*8-1:0] regFlat;
  wire             sdaLine = mSda & ~sdaDrvLow;

  ctrl_bus_slave u_ctrl_bus_slave (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .sclIn(mScl), .sdaIn(sdaLine),
    .sdaDrvLow(sdaDrvLow), .statusIn(statusIn), .regFlat(regFlat)
  );

  int         nRun = 0;
  int         nFail = 0;
  int         drvViol = 0;
  int         offDrive = 0;
  logic       prevDrv = 1'b0;
  logic [7:0] model [NREG];

  // R8 / R7 monitor on the pins
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (sdaDrvLow !== prevDrv && mScl === 1'b1) drvViol++;
      if (pwrGood === 1'b0 && sdaDrvLow === 1'b1) offDrive++;
    end
    prevDrv = sdaDrvLow;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [NREG*8-1:0] modelFlat();
    logic [NREG*8-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  function automatic bit expAck(input logic [7:0] a);
    return a[7:1] == 7'h46;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    mSda = 1'b1; idle(Q);
    mScl = 1'b1; idle(Q);
    mSda = 1'b0; idle(Q);
    mScl = 1'b0; idle(Q);
  endtask

  task automatic stopCond();
    mSda = 1'b0; idle(Q);
    mScl = 1'b1; idle(Q);
    mSda = 1'b1; idle(Q);
  endtask

  task automatic wbit(input bit b, input bit glitch);
    mSda = b; idle(Q);
    mScl = 1'b1;
    if (glitch) begin
      idle(3); mSda = ~b; idle(2); mSda = b;
      idle(3); mScl = 1'b0; idle(2); mScl = 1'b1;
      idle(Q - 10);
    end else begin
      idle(Q);
    end
    mScl = 1'b0; idle(Q);
  endtask

  task automatic rbit(output bit b);
    mSda = 1'b1; idle(Q);
    mScl = 1'b1; idle(Q / 2);
    b = sdaLine;
    idle(Q - Q / 2);
    mScl = 1'b0; idle(Q);
  endtask

  task automatic sendByte(input logic [7:0] d, input bit glitch, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) wbit(d[i], glitch && (i == 3 || i == 6));
    rbit(a);
    ack = ~a;
  endtask

  task automatic readByte(output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(1'b1, 1'b0);
  endtask

  task automatic writeBurst(input logic [7:0] sub, input int n, input bit glitch);
    bit ack;
    logic [7:0] d;
    startCond();
    sendByte(8'h8C, 1'b0, ack);
    check(ack == expAck(8'h8C), "R1", "write address ack", 128'(ack), 128'(1));
    sendByte(sub, 1'b0, ack);
    check(ack, "R3", "subaddress ack", 128'(ack), 128'(1));
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      sendByte(d, glitch, ack);
      check(ack, "R3", "data ack", 128'(ack), 128'(1));
      model[(int'(sub) + k) % NREG] = d;
    end
    stopCond();
    idle(4);
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    finishRun();
  end

  initial begin
    bit ack;
    logic [7:0] rd;
    void'($urandom(32'h5EED_0042));
    rstN = 1'b0; pwrGood = 1'b1; mScl = 1'b1; mSda = 1'b1; statusIn = 8'h00;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    idle(10);
    check(sdaDrvLow == 1'b0, "R9", "drive in reset", 128'(sdaDrvLow), 128'(0));
    rstN = 1'b1;
    idle(10);
    check(regFlat == modelFlat(), "R9", "registers after reset", regFlat, modelFlat());
    check(sdaDrvLow == 1'b0, "R9", "drive after reset", 128'(sdaDrvLow), 128'(0));

    // R3 directed wrap and out-of-range subaddress, then random bursts
    writeBurst(8'd14, 4, 1'b0);
    check(regFlat == modelFlat(), "R3", "wrap at top", regFlat, modelFlat());
    writeBurst(8'h3F, 2, 1'b0);
    check(regFlat == modelFlat(), "R3", "subaddress modulo", regFlat, modelFlat());
    for (int t = 0; t < 6; t++) begin
      writeBurst(8'($urandom % 32), 1 + int'($urandom % 4), 1'b0);
      check(regFlat == modelFlat(), "R3", "random burst", regFlat, modelFlat());
    end

    // R2 foreign addresses
    foreach (rd[i]) ; // no-op keeps rd declared use simple
    begin
      logic [7:0] bad [3] = '{8'h8E, 8'h4C, 8'h8B};
      for (int t = 0; t < 3; t++) begin
        startCond();
        sendByte(bad[t], 1'b0, ack);
        check(ack == expAck(bad[t]), "R2", "foreign address ack", 128'(ack), 128'(0));
        sendByte(8'h02, 1'b0, ack);
        check(!ack, "R2", "byte after mismatch ack", 128'(ack), 128'(0));
        sendByte(8'hE7, 1'b0, ack);
        check(!ack, "R2", "data after mismatch ack", 128'(ack), 128'(0));
        stopCond();
        idle(4);
        check(regFlat == modelFlat(), "R2", "registers after mismatch", regFlat, modelFlat());
      end
    end

    // R4 repeated start with new subaddress
    startCond();
    sendByte(8'h8C, 1'b0, ack);
    sendByte(8'd5, 1'b0, ack);
    sendByte(8'h5A, 1'b0, ack);
    model[5] = 8'h5A;
    startCond();
    sendByte(8'h8C, 1'b0, ack);
    check(ack, "R4", "address after repeated start", 128'(ack), 128'(1));
    sendByte(8'd9, 1'b0, ack);
    sendByte(8'hC3, 1'b0, ack);
    sendByte(8'h3C, 1'b0, ack);
    model[9] = 8'hC3; model[10] = 8'h3C;
    stopCond();
    idle(4);
    check(regFlat == modelFlat(), "R4", "registers after repeated start", regFlat, modelFlat());

    // R5 status reads
    for (int t = 0; t < 4; t++) begin
      statusIn = (t == 0) ? 8'hA5 : (t == 1) ? 8'h00 : 8'($urandom);
      startCond();
      sendByte(8'h8D, 1'b0, ack);
      check(ack == expAck(8'h8D), "R1", "read address ack", 128'(ack), 128'(1));
      readByte(rd);
      check(rd == statusIn, "R5", "status byte", 128'(rd), 128'(statusIn));
      stopCond();
      idle(4);
    end

    // R6 glitches on both lines during data bytes
    writeBurst(8'd2, 3, 1'b1);
    check(regFlat == modelFlat(), "R6", "burst with glitches", regFlat, modelFlat());

    // R7 power-good low
    writeBurst(8'd0, 4, 1'b0);
    pwrGood = 1'b0;
    idle(5);
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    check(regFlat == modelFlat(), "R7", "registers without power", regFlat, modelFlat());
    startCond();
    sendByte(8'h8C, 1'b0, ack);
    check(!ack, "R7", "address ack without power", 128'(ack), 128'(0));
    sendByte(8'd1, 1'b0, ack);
    sendByte(8'hFF, 1'b0, ack);
    stopCond();
    idle(4);
    check(regFlat == modelFlat(), "R7", "no write without power", regFlat, modelFlat());
    check(offDrive == 0, "R7", "drive cycles without power", 128'(offDrive), 128'(0));
    pwrGood = 1'b1;
    idle(5);
    writeBurst(8'd7, 2, 1'b0);
    check(regFlat == modelFlat(), "R7", "writes after power returns", regFlat, modelFlat());

    check(drvViol == 0, "R8", "drive changes with clock high", 128'(drvViol), 128'(0));
    finishRun();
  end

endmodule